// File: doc/BRIEF.md
# Alternating Forward/Backward State-Metric Unit

This block performs the state-metric recursion for an 8-state recursive systematic constituent code. It has one add-compare-select datapath, and that datapath computes both the forward (alpha) metrics and the backward (beta) metrics. A free-running phase bit gives even cycles to the forward recursion and odd cycles to the backward recursion. A register splits the datapath into two stages. The first stage adds branch metrics to the old state metrics and compares each pair of candidates. The second stage selects the winners, normalizes them and saturates them. Because the two recursions do not depend on each other, the two stages always hold work of opposite direction, and each recursion still gets a fresh result back in time for its next step.

The branch unit presents four branch metrics each cycle, one for each (systematic, parity) label, with a valid flag. The only difference between the directions is the mapping from labels to states, and the phase bit picks it. No branch metrics are stored. Every accepted step produces a metric vector two clocks later, tagged forward or backward, for the LLR stage that follows. A start pulse loads the initial state of both recursions at block boundaries.

Top module: `ab_metric_unit`

## Requirements
- R1: After reset `out_valid` is 0 and `phase_beta` is 0. Both recursions hold their initial vector: state 0 at 0, every other state at the most negative MW-bit value.
- R2: `phase_beta` toggles every cycle. If `blk_start` was high at an edge, `phase_beta` is 0 (forward) in the next cycle.
- R3: An input sampled with `bm_valid`=1 and `blk_start`=0 leads to `out_valid`=1 after the second following edge. At that point `out_beta` equals the `phase_beta` value at acceptance. No output appears without such an input, so consecutive valid outputs alternate in direction.
- R4: Forward step. The state index is 4·r1+2·r2+r3, where r1 is the newest shift-register bit. Input bit u gives feedback a=u⊕r2⊕r3, next state {a,r1,r2} and parity p=a⊕r1⊕r3. The new alpha of each state is the maximum, over the two transitions into it, of the old alpha plus the branch metric with label 2u+p. That branch metric is the signed GW-bit slice k·GW of `bm_gamma`, with k=2u+p.
- R5: Backward step. The new beta of state s is the maximum, over u∈{0,1}, of the old beta of the next state plus the branch metric with label 2u+p. The trellis is the same as in R4.
- R6: Before output, every new vector has state 0's value subtracted from all its states, so state 0 of every output is 0.
- R7: After normalization each metric is clamped to the signed MW-bit range. State s appears at `out_metric[s*MW +: MW]`. GW must not exceed MW.
- R8: An edge with `blk_start`=1 reloads both recursions with the R1 initial vector. It also discards any step still in the pipeline and ignores the input sampled at that edge.
- R9: The forward and backward recursions never affect each other. Each output depends only on the previous result of its own direction.
- R10: A cycle with `bm_valid`=0 produces no output and leaves the metrics of that cycle's direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Reinitialize both recursions and flush the pipeline |
| bm_valid | input | 1 | Branch metrics valid for the current phase |
| bm_gamma | input | 4*GW | Four signed branch metrics, label k=2u+p at slice k*GW |
| phase_beta | output | 1 | Direction accepted this cycle (0 forward, 1 backward) |
| out_valid | output | 1 | Result vector valid |
| out_beta | output | 1 | Direction of the result vector |
| out_metric | output | 8*MW | Normalized, saturated state metrics, state s at slice s*MW |

## Verification
The scoreboard runs its own sequential max-log model for each direction. The bench interleaves random branch metrics, so a design that fed one direction's state into the other, or that read a metric register before its update, produces vectors that diverge within a few steps. Gaps in `bm_valid` show whether idle phases leave a direction's state untouched or silently advance it. A start pulse arrives with a step still in flight; a design that let that step through, or that did not reset the phase, emits an extra or mislabeled vector. Extreme branch metrics force normalized differences past the MW-bit range, where a missing clamp wraps to a large positive metric.

// File: rtl/ab_trellis_pkg.sv
package ab_trellis_pkg;
  localparam int NSTATE = 8;
  localparam int NLABEL = 4;

  // forward: j-th source state of target t (shift register holds {r1,r2,r3})
  function automatic logic [2:0] fwd_src(input logic [2:0] t, input logic j);
    return {t[1:0], j};
  endfunction

  // forward: branch label {u,p} of the j-th transition into t
  function automatic logic [1:0] fwd_lbl(input logic [2:0] t, input logic j);
    logic u, p;
    u = t[2] ^ t[0] ^ j;
    p = t[2] ^ t[1] ^ j;
    return {u, p};
  endfunction

  // backward: successor of state s under input bit j
  function automatic logic [2:0] bwd_dst(input logic [2:0] s, input logic j);
    logic a;
    a = j ^ s[1] ^ s[0];
    return {a, s[2], s[1]};
  endfunction

  // backward: branch label {u,p} of state s under input bit j
  function automatic logic [1:0] bwd_lbl(input logic [2:0] s, input logic j);
    logic a;
    a = j ^ s[1] ^ s[0];
    return {j, a ^ s[2] ^ s[0]};
  endfunction
endpackage

// File: rtl/ab_phase_ctrl.sv
module ab_phase_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic phase_beta
);
  always_ff @(posedge clk) begin
    if (!rst_n)       phase_beta <= 1'b0;
    else if (restart) phase_beta <= 1'b0;
    else              phase_beta <= ~phase_beta;
  end
endmodule

// File: rtl/ab_metric_bank.sv
module ab_metric_bank
  import ab_trellis_pkg::*;
#(
  parameter int MW = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     wr_en,
  input  logic                     wr_beta,
  input  logic [NSTATE-1:0][MW-1:0] wr_vec,
  input  logic                     rd_beta,
  output logic [NSTATE-1:0][MW-1:0] rd_vec
);
  function automatic logic [NSTATE-1:0][MW-1:0] init_vec();
    logic [NSTATE-1:0][MW-1:0] v;
    for (int s = 0; s < NSTATE; s++)
      v[s] = (s == 0) ? '0 : {1'b1, {(MW-1){1'b0}}};
    return v;
  endfunction

  localparam logic [NSTATE-1:0][MW-1:0] INIT = init_vec();

  logic [NSTATE-1:0][MW-1:0] alpha_q, beta_q;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      alpha_q <= INIT;
      beta_q  <= INIT;
    end else if (wr_en) begin
      if (wr_beta) beta_q  <= wr_vec;
      else         alpha_q <= wr_vec;
    end
  end

  assign rd_vec = rd_beta ? beta_q : alpha_q;
endmodule

// File: rtl/ab_acs_addcmp.sv
module ab_acs_addcmp
  import ab_trellis_pkg::*;
#(
  parameter int MW = 9,
  parameter int GW = 7,
  localparam int WW = MW + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      in_valid,
  input  logic                      in_beta,
  input  logic [NSTATE-1:0][MW-1:0] cur,
  input  logic [NLABEL-1:0][GW-1:0] gam,
  output logic                      s1_valid,
  output logic                      s1_beta,
  output logic [NSTATE-1:0][WW-1:0] s1_c0,
  output logic [NSTATE-1:0][WW-1:0] s1_c1,
  output logic [NSTATE-1:0]         s1_pick
);
  function automatic logic [WW-1:0] ext_m(input logic [MW-1:0] v);
    return {{(WW-MW){v[MW-1]}}, v};
  endfunction

  function automatic logic [WW-1:0] ext_g(input logic [GW-1:0] v);
    return {{(WW-GW){v[GW-1]}}, v};
  endfunction

  logic [NSTATE-1:0][WW-1:0] c0, c1;
  logic [NSTATE-1:0]         pick;

  for (genvar t = 0; t < NSTATE; t++) begin : g_st
    logic [2:0] ix0, ix1;
    logic [1:0] lb0, lb1;
    always_comb begin
      if (in_beta) begin
        ix0 = bwd_dst(3'(t), 1'b0);
        ix1 = bwd_dst(3'(t), 1'b1);
        lb0 = bwd_lbl(3'(t), 1'b0);
        lb1 = bwd_lbl(3'(t), 1'b1);
      end else begin
        ix0 = fwd_src(3'(t), 1'b0);
        ix1 = fwd_src(3'(t), 1'b1);
        lb0 = fwd_lbl(3'(t), 1'b0);
        lb1 = fwd_lbl(3'(t), 1'b1);
      end
    end
    assign c0[t]   = ext_m(cur[ix0]) + ext_g(gam[lb0]);
    assign c1[t]   = ext_m(cur[ix1]) + ext_g(gam[lb1]);
    assign pick[t] = $signed(c1[t]) > $signed(c0[t]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_beta  <= 1'b0;
      s1_c0    <= '0;
      s1_c1    <= '0;
      s1_pick  <= '0;
    end else begin
      s1_valid <= in_valid && !flush;
      s1_beta  <= in_beta;
      s1_c0    <= c0;
      s1_c1    <= c1;
      s1_pick  <= pick;
    end
  end
endmodule

// File: rtl/ab_acs_selnorm.sv
module ab_acs_selnorm
  import ab_trellis_pkg::*;
#(
  parameter int MW = 9,
  localparam int WW = MW + 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic                      s1_valid,
  input  logic                      s1_beta,
  input  logic [NSTATE-1:0][WW-1:0] s1_c0,
  input  logic [NSTATE-1:0][WW-1:0] s1_c1,
  input  logic [NSTATE-1:0]         s1_pick,
  output logic                      res_valid,
  output logic                      res_beta,
  output logic [NSTATE-1:0][MW-1:0] res_vec,
  output logic                      out_valid,
  output logic                      out_beta,
  output logic [NSTATE-1:0][MW-1:0] out_vec
);
  localparam int HI_I = (1 << (MW-1)) - 1;
  localparam logic signed [WW-1:0] HI = WW'(HI_I);
  localparam logic signed [WW-1:0] LO = WW'(-HI_I - 1);

  function automatic logic [MW-1:0] sat(input logic signed [WW-1:0] v);
    if (v > HI)      return HI[MW-1:0];
    else if (v < LO) return LO[MW-1:0];
    else             return v[MW-1:0];
  endfunction

  logic signed [WW-1:0] win  [NSTATE];
  logic signed [WW-1:0] diff [NSTATE];

  always_comb begin
    for (int t = 0; t < NSTATE; t++)
      win[t] = s1_pick[t] ? $signed(s1_c1[t]) : $signed(s1_c0[t]);
    for (int t = 0; t < NSTATE; t++) begin
      diff[t]    = win[t] - win[0];
      res_vec[t] = sat(diff[t]);
    end
  end

  assign res_valid = s1_valid && !flush;
  assign res_beta  = s1_beta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_beta  <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= res_valid;
      out_beta  <= res_beta;
      out_vec   <= res_vec;
    end
  end
endmodule

// File: rtl/ab_metric_unit.sv
module ab_metric_unit
  import ab_trellis_pkg::*;
#(
  parameter int MW = 9,
  parameter int GW = 7,
  localparam int WW = MW + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   blk_start,
  input  logic                   bm_valid,
  input  logic [NLABEL*GW-1:0]   bm_gamma,
  output logic                   phase_beta,
  output logic                   out_valid,
  output logic                   out_beta,
  output logic [NSTATE*MW-1:0]   out_metric
);
  // named events for the checker
  logic acc_evt;
  logic upd_evt;

  logic [NSTATE-1:0][MW-1:0] cur_vec, res_vec, out_vec;
  logic [NLABEL-1:0][GW-1:0] gam;
  logic                      s1_valid, s1_beta, res_beta;
  logic [NSTATE-1:0][WW-1:0] s1_c0, s1_c1;
  logic [NSTATE-1:0]         s1_pick;

  assign acc_evt    = bm_valid && !blk_start;
  assign gam        = bm_gamma;
  assign out_metric = out_vec;

  ab_phase_ctrl i_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (blk_start),
    .phase_beta (phase_beta)
  );

  ab_metric_bank #(.MW(MW)) i_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (blk_start),
    .wr_en   (upd_evt),
    .wr_beta (res_beta),
    .wr_vec  (res_vec),
    .rd_beta (phase_beta),
    .rd_vec  (cur_vec)
  );

  ab_acs_addcmp #(.MW(MW), .GW(GW)) i_addcmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (blk_start),
    .in_valid (acc_evt),
    .in_beta  (phase_beta),
    .cur      (cur_vec),
    .gam      (gam),
    .s1_valid (s1_valid),
    .s1_beta  (s1_beta),
    .s1_c0    (s1_c0),
    .s1_c1    (s1_c1),
    .s1_pick  (s1_pick)
  );

  ab_acs_selnorm #(.MW(MW)) i_selnorm (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (blk_start),
    .s1_valid  (s1_valid),
    .s1_beta   (s1_beta),
    .s1_c0     (s1_c0),
    .s1_c1     (s1_c1),
    .s1_pick   (s1_pick),
    .res_valid (upd_evt),
    .res_beta  (res_beta),
    .res_vec   (res_vec),
    .out_valid (out_valid),
    .out_beta  (out_beta),
    .out_vec   (out_vec)
  );
endmodule

// File: rtl/ab_metric_unit_chk.sv
module ab_metric_unit_chk #(
  parameter int MW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          blk_start,
  input logic          acc_evt,
  input logic          phase_beta,
  input logic          out_valid,
  input logic          out_beta,
  input logic [MW-1:0] m0
);
  AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> phase_beta != $past(phase_beta)); // R2

  AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !phase_beta); // R2

  AST_STEP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt ##1 !blk_start |=> out_valid && (out_beta == $past(phase_beta, 2))); // R3

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(acc_evt, 2)); // R3

  AST_DIR_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_beta != $past(out_beta)); // R3

  AST_NORM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> m0 == '0); // R6

  AST_START_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !out_valid); // R8
endmodule

bind ab_metric_unit ab_metric_unit_chk #(.MW(MW)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .blk_start  (blk_start),
  .acc_evt    (acc_evt),
  .phase_beta (phase_beta),
  .out_valid  (out_valid),
  .out_beta   (out_beta),
  .m0         (out_metric[MW-1:0])
);

// File: tb/test_ab_metric_unit.sv
module test_ab_metric_unit;
  localparam int MW = 9;
  localparam int GW = 7;
  localparam int NS = 8;
  localparam int HI = (1 << (MW-1)) - 1;
  localparam int LO = -HI - 1;
  localparam int GHI = (1 << (GW-1)) - 1;
  localparam int GLO = -GHI - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              blk_start = 1'b0;
  logic              bm_valid = 1'b0;
  logic [4*GW-1:0]   bm_gamma = '0;
  logic              phase_beta, out_valid, out_beta;
  logic [NS*MW-1:0]  out_metric;

  always #10 clk = ~clk;

  ab_metric_unit i_ab_metric_unit (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .bm_valid(bm_valid),
    .bm_gamma(bm_gamma), .phase_beta(phase_beta), .out_valid(out_valid),
    .out_beta(out_beta), .out_metric(out_metric)
  );

  typedef struct packed {
    logic [31:0]      due;
    logic             beta;
    logic [NS*MW-1:0] vec;
  } exp_t;

  exp_t q[$];
  int   total = 0, bad = 0, cyc = 0;
  bit   ph = 1'b0, run = 1'b0;
  int   ma[NS], mb[NS];

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // shift-register encoder written out directly
  function automatic int enc_next(input int s, input int u);
    int r1 = (s >> 2) & 1, r2 = (s >> 1) & 1, r3 = s & 1;
    int fb = u ^ r2 ^ r3;
    return fb * 4 + r1 * 2 + r2;
  endfunction

  function automatic int enc_par(input int s, input int u);
    int r1 = (s >> 2) & 1, r2 = (s >> 1) & 1, r3 = s & 1;
    return (u ^ r2 ^ r3) ^ r1 ^ r3;
  endfunction

  task automatic model_init();
    for (int s = 0; s < NS; s++) begin
      ma[s] = (s == 0) ? 0 : LO;
      mb[s] = (s == 0) ? 0 : LO;
    end
  endtask

  task automatic model_step(input bit beta, input logic [4*GW-1:0] gv, output logic [NS*MW-1:0] vec);
    int g[4];
    int nw[NS];
    for (int k = 0; k < 4; k++) g[k] = int'($signed(gv[k*GW +: GW]));
    for (int s = 0; s < NS; s++) nw[s] = -1000000;
    for (int s = 0; s < NS; s++)
      for (int u = 0; u < 2; u++) begin
        int lbl = 2 * u + enc_par(s, u);
        int ns  = enc_next(s, u);
        if (!beta) begin
          if (ma[s] + g[lbl] > nw[ns]) nw[ns] = ma[s] + g[lbl];
        end else begin
          if (mb[ns] + g[lbl] > nw[s]) nw[s] = mb[ns] + g[lbl];
        end
      end
    for (int s = NS - 1; s >= 0; s--) begin
      int d = nw[s] - nw[0];
      if (d > HI) d = HI;
      if (d < LO) d = LO;
      if (beta) mb[s] = d; else ma[s] = d;
      vec[s*MW +: MW] = d[MW-1:0];
    end
  endtask

  // driver: called at a negedge, returns at the next negedge
  task automatic step(input bit v, input bit st, input logic [4*GW-1:0] gv);
    exp_t it;
    logic [NS*MW-1:0] vec;
    bm_valid  = v;
    blk_start = st;
    bm_gamma  = gv;
    @(posedge clk);
    #1;
    cyc++;
    if (st) begin
      q.delete();
      model_init();
    end else if (v) begin
      model_step(ph, gv, vec);
      it.due  = cyc + 1;
      it.beta = ph;
      it.vec  = vec;
      q.push_back(it);
    end
    ph = st ? 1'b0 : ~ph;
    @(negedge clk);
  endtask

  function automatic logic [4*GW-1:0] rnd_gam();
    logic [4*GW-1:0] gv;
    for (int k = 0; k < 4; k++) gv[k*GW +: GW] = GW'($urandom_range(0, (1 << GW) - 1));
    return gv;
  endfunction

  function automatic logic [4*GW-1:0] ext_gam();
    logic [4*GW-1:0] gv;
    for (int k = 0; k < 4; k++) gv[k*GW +: GW] = ($urandom_range(0, 1) == 1) ? GW'(GHI) : GW'(GLO);
    return gv;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (run) begin
      bit exp_v;
      exp_t it;
      exp_v = (q.size() > 0) && (q[0].due == cyc);
      chk(out_valid == exp_v, "R3 R10 out_valid", 128'(out_valid), 128'(exp_v));
      chk(phase_beta == ph, "R2 phase_beta", 128'(phase_beta), 128'(ph));
      if (exp_v) begin
        it = q.pop_front();
        chk(out_beta == it.beta, "R3 direction tag", 128'(out_beta), 128'(it.beta));
        if (it.beta)
          chk(out_metric == it.vec, "R5 R6 R7 R9 beta vector", 128'(out_metric), 128'(it.vec));
        else
          chk(out_metric == it.vec, "R4 R6 R7 R9 alpha vector", 128'(out_metric), 128'(it.vec));
      end
    end
  end

  initial begin
    #(20 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_init();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 reset out_valid", 128'(out_valid), 128'(0));
    chk(phase_beta == 1'b0, "R1 reset phase", 128'(phase_beta), 128'(0));
    run = 1'b1;
    // R4 R5 R9: dense interleaved random steps from the reset state
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, rnd_gam());
    // R10: random idle phases in either direction
    for (int i = 0; i < 80; i++) step($urandom_range(0, 1) == 1, 1'b0, rnd_gam());
    // R8: start while steps are in flight, with valid asserted on the start cycle
    step(1'b1, 1'b0, rnd_gam());
    step(1'b1, 1'b1, rnd_gam());
    for (int i = 0; i < 30; i++) step(1'b1, 1'b0, rnd_gam());
    // R8: start right after a single step (in stage one)
    step(1'b1, 1'b0, rnd_gam());
    step(1'b0, 1'b1, rnd_gam());
    // R7: extreme branch metrics drive normalized values out of range
    for (int i = 0; i < 60; i++) step(1'b1, 1'b0, ext_gam());
    // R10: only backward phases carry data, then only forward
    for (int i = 0; i < 20; i++) step(ph, 1'b0, rnd_gam());
    for (int i = 0; i < 20; i++) step(!ph, 1'b0, rnd_gam());
    repeat (4) step(1'b0, 1'b0, '0);
    chk(q.size() == 0, "R3 all steps delivered", 128'(q.size()), 128'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule